// File: doc/BRIEF.md
# Register-Direct Integer Instruction Executor

This block runs a small set of two-operand, 32-bit integer instructions whose operands are both registers. Bytes arrive one per valid/ready beat. The first byte of an instruction is the opcode and the second is the operand-selector byte. The block decodes the selector, reads its eight-entry register file and evaluates the operation. It then writes the result back and updates a sign, zero and overflow flag set. On every retirement it pulses `done` and reports the computed value and the destination index.

The operand-selector byte has three fields. The top two bits give the addressing mode. The middle three bits name the source register. The low three bits name the destination register, which is also the first operand. Only the register-direct mode (top bits `11`) executes. Any other mode, and any opcode outside the supported set, retires as a fault: `fault` is high, no register is written and the flags keep their values. After reset, register i holds (i+1) × `INIT_SEED` modulo 2^32. Software can therefore observe or build values using only the instructions themselves.

Top module: `regdirect_exec`

## Requirements
- R1: After reset, `byte_ready` is 1, `done`, `fault` and `wr_en` are 0, all three flags are 0, and register i holds (i+1)×0x9E3779B9 mod 2^32.
- R2: A byte is consumed only on a cycle with `byte_valid` and `byte_ready` both high. The first byte consumed is the opcode and the second is the selector. `byte_ready` is low during the cycle right after the selector is consumed.
- R3: `done` is high for exactly the one cycle that follows the clock edge after selector acceptance. `fault` and `wr_en` are 0 whenever `done` is 0.
- R4: The selector decodes as mode = bits 7:6, source = bits 5:3 and destination = bits 2:0. `wr_idx` reports the destination.
- R5: Opcode 0x01 writes dst+src and opcode 0x29 writes dst−src. OF is set when the exact signed result does not fit in 32 bits.
- R6: Opcodes 0x21, 0x09 and 0x31 write dst AND src, dst OR src and dst XOR src, and clear OF.
- R7: Every flag-updating instruction sets SF to bit 31 of its 32-bit result and ZF when that result is zero. Flags change only at a retirement.
- R8: Opcode 0x39 produces dst−src on `result` and sets SF, ZF and OF as a subtraction would. It writes no register.
- R9: Opcode 0x89 writes src into dst and leaves all flags unchanged.
- R10: Opcode 0xF7 writes the bitwise complement of dst, clears OF and ignores the source field.
- R11: A selector whose mode is not 3 retires with `fault`=1, no register write and unchanged flags.
- R12: An opcode outside the set above retires with `fault`=1, no register write and unchanged flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | Instruction byte present |
| byte_in | input | 8 | Instruction byte |
| byte_ready | output | 1 | Block accepts a byte this cycle |
| done | output | 1 | One-cycle retirement pulse |
| fault | output | 1 | Retired instruction was rejected |
| wr_en | output | 1 | Retired instruction wrote a register |
| wr_idx | output | 3 | Destination register of the retired instruction |
| result | output | 32 | Value computed by the retired instruction |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |
| flag_o | output | 1 | Overflow flag |

## Verification
An instruction's results appear on the outputs in the cycle after the edge that follows selector acceptance. At that point `done`, `fault`, `wr_en`, `wr_idx`, `result` and the new flags all become visible together. The bench records the due cycle of each instruction when its selector is accepted, on the falling edge after acceptance, and sets it to that cycle count plus one. On every falling edge it compares `done` against whether an instruction is due. When one is due, its reference model computes the expected values from its own register copy. `byte_ready` is checked low in the cycle right after each selector is accepted. The flags are compared on every cycle, so a change outside a retirement is also caught.

// File: rtl/rde_pkg.sv
package rde_pkg;

    localparam int DW = 32;

    localparam logic [7:0] OPB_ADD = 8'h01;
    localparam logic [7:0] OPB_OR  = 8'h09;
    localparam logic [7:0] OPB_AND = 8'h21;
    localparam logic [7:0] OPB_SUB = 8'h29;
    localparam logic [7:0] OPB_XOR = 8'h31;
    localparam logic [7:0] OPB_CMP = 8'h39;
    localparam logic [7:0] OPB_MOV = 8'h89;
    localparam logic [7:0] OPB_NOT = 8'hF7;

    localparam logic [1:0] MODE_REG = 2'b11;

    typedef enum logic [3:0] {
        K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_CMP, K_MOV, K_NOT, K_BAD
    } alu_kind_e;

    typedef enum logic [1:0] {ST_OPC, ST_SEL, ST_EXEC} fetch_st_e;

    typedef struct packed {
        logic [1:0] mode;
        logic [2:0] src;
        logic [2:0] dst;
    } selector_t;

    typedef struct packed {
        alu_kind_e kind;
        selector_t sel;
    } insn_t;

    typedef struct packed {
        logic [DW-1:0] value;
        logic          sf;
        logic          zf;
        logic          of;
        logic          write;
        logic          touch_flags;
        logic          fault;
    } outcome_t;

    function automatic alu_kind_e decode_kind(logic [7:0] b);
        case (b)
            OPB_ADD: return K_ADD;
            OPB_SUB: return K_SUB;
            OPB_AND: return K_AND;
            OPB_OR:  return K_OR;
            OPB_XOR: return K_XOR;
            OPB_CMP: return K_CMP;
            OPB_MOV: return K_MOV;
            OPB_NOT: return K_NOT;
            default: return K_BAD;
        endcase
    endfunction

    // a: destination operand, b: source operand
    function automatic outcome_t evaluate(insn_t i, logic [DW-1:0] a, logic [DW-1:0] b);
        outcome_t o;
        o = '0;
        case (i.kind)
            K_ADD: begin
                o.value = a + b;
                o.of = (a[DW-1] == b[DW-1]) && (o.value[DW-1] != a[DW-1]);
                o.write = 1'b1; o.touch_flags = 1'b1;
            end
            K_SUB, K_CMP: begin
                o.value = a - b;
                o.of = (a[DW-1] != b[DW-1]) && (o.value[DW-1] != a[DW-1]);
                o.write = (i.kind == K_SUB); o.touch_flags = 1'b1;
            end
            K_AND: begin o.value = a & b; o.write = 1'b1; o.touch_flags = 1'b1; end
            K_OR:  begin o.value = a | b; o.write = 1'b1; o.touch_flags = 1'b1; end
            K_XOR: begin o.value = a ^ b; o.write = 1'b1; o.touch_flags = 1'b1; end
            K_MOV: begin o.value = b;     o.write = 1'b1; end
            K_NOT: begin o.value = ~a;    o.write = 1'b1; o.touch_flags = 1'b1; end
            default: o.fault = 1'b1;
        endcase
        if (i.sel.mode != MODE_REG) o.fault = 1'b1;
        if (o.fault) begin
            o.value = '0; o.of = 1'b0; o.write = 1'b0; o.touch_flags = 1'b0;
        end
        o.sf = o.value[DW-1];
        o.zf = (o.value == '0);
        return o;
    endfunction

endpackage

// File: rtl/rde_fetch.sv
module rde_fetch
    import rde_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       byte_valid,
    input  logic [7:0] byte_in,
    output logic       byte_ready,
    output logic       exec_vld,
    output insn_t      insn
);
    fetch_st_e st_q;
    insn_t     insn_q;

    assign byte_ready = (st_q != ST_EXEC);
    assign exec_vld   = (st_q == ST_EXEC);
    assign insn       = insn_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_OPC;
            insn_q <= '{kind: K_BAD, sel: '0};
        end else begin
            case (st_q)
                ST_OPC: if (byte_valid) begin
                    insn_q.kind <= decode_kind(byte_in);
                    st_q        <= ST_SEL;
                end
                ST_SEL: if (byte_valid) begin
                    insn_q.sel <= selector_t'(byte_in);
                    st_q       <= ST_EXEC;
                end
                default: st_q <= ST_OPC;
            endcase
        end
    end
endmodule

// File: rtl/rde_regfile.sv
module rde_regfile #(
    parameter int          NREGS = 8,
    parameter int          DW    = 32,
    parameter logic [31:0] SEED  = 32'h9E3779B9,
    localparam int         IW    = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] ra_idx,
    output logic [DW-1:0] ra_data,
    input  logic [IW-1:0] rb_idx,
    output logic [DW-1:0] rb_data
);
    logic [DW-1:0] regs [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        logic [DW-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)                            q <= DW'(SEED * 32'(g + 1));
            else if (we && widx == IW'(g))      q <= wdata;
        end
        assign regs[g] = q;
    end

    assign ra_data = regs[ra_idx];
    assign rb_data = regs[rb_idx];
endmodule

// File: rtl/regdirect_exec.sv
module regdirect_exec
    import rde_pkg::*;
#(
    parameter int          NREGS     = 8,
    parameter logic [31:0] INIT_SEED = 32'h9E3779B9,
    localparam int         IW        = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          byte_valid,
    input  logic [7:0]    byte_in,
    output logic          byte_ready,
    output logic          done,
    output logic          fault,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic [DW-1:0] result,
    output logic          flag_s,
    output logic          flag_z,
    output logic          flag_o
);
    logic          exec_vld;
    insn_t         insn;
    logic [DW-1:0] dst_val, src_val;
    outcome_t      oc;

    rde_fetch u_fetch (
        .clk        (clk),
        .rst        (rst),
        .byte_valid (byte_valid),
        .byte_in    (byte_in),
        .byte_ready (byte_ready),
        .exec_vld   (exec_vld),
        .insn       (insn)
    );

    rde_regfile #(.NREGS(NREGS), .DW(DW), .SEED(INIT_SEED)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (exec_vld && oc.write),
        .widx    (IW'(insn.sel.dst)),
        .wdata   (oc.value),
        .ra_idx  (IW'(insn.sel.dst)),
        .ra_data (dst_val),
        .rb_idx  (IW'(insn.sel.src)),
        .rb_data (src_val)
    );

    always_comb oc = evaluate(insn, dst_val, src_val);

    always_ff @(posedge clk) begin
        if (rst) begin
            done   <= 1'b0;
            fault  <= 1'b0;
            wr_en  <= 1'b0;
            wr_idx <= '0;
            result <= '0;
            flag_s <= 1'b0;
            flag_z <= 1'b0;
            flag_o <= 1'b0;
        end else begin
            done  <= exec_vld;
            fault <= exec_vld && oc.fault;
            wr_en <= exec_vld && oc.write;
            if (exec_vld) begin
                wr_idx <= IW'(insn.sel.dst);
                result <= oc.value;
                if (oc.touch_flags) begin
                    flag_s <= oc.sf;
                    flag_z <= oc.zf;
                    flag_o <= oc.of;
                end
            end
        end
    end
endmodule

// File: rtl/rde_checker.sv
module rde_checker (
    input logic clk,
    input logic rst,
    input logic byte_ready,
    input logic done,
    input logic fault,
    input logic wr_en,
    input logic flag_s,
    input logic flag_z,
    input logic flag_o
);
    a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r2_ready_dropped: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(!byte_ready));

    a_r3_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !done |-> (!fault && !wr_en));

    a_r11_fault_no_write: assert property (@(posedge clk) disable iff (rst)
        fault |-> !wr_en);

    a_r11_fault_flags_hold: assert property (@(posedge clk) disable iff (rst)
        fault |-> $stable({flag_s, flag_z, flag_o}));

    a_r7_flags_only_on_retire: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable({flag_s, flag_z, flag_o}));
endmodule

bind regdirect_exec rde_checker chk_i (
    .clk        (clk),
    .rst        (rst),
    .byte_ready (byte_ready),
    .done       (done),
    .fault      (fault),
    .wr_en      (wr_en),
    .flag_s     (flag_s),
    .flag_z     (flag_z),
    .flag_o     (flag_o)
);

// File: tb/regdirect_exec_tb_top.sv
`timescale 1ns/1ps
module regdirect_exec_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        byte_valid;
    logic [7:0]  byte_in;
    logic        byte_ready, done, fault, wr_en;
    logic [2:0]  wr_idx;
    logic [31:0] result;
    logic        flag_s, flag_z, flag_o;

    always #10 clk = ~clk;

    regdirect_exec dut_i (
        .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_in(byte_in),
        .byte_ready(byte_ready), .done(done), .fault(fault), .wr_en(wr_en),
        .wr_idx(wr_idx), .result(result), .flag_s(flag_s), .flag_z(flag_z),
        .flag_o(flag_o)
    );

    typedef struct { logic [7:0] op; logic [7:0] sel; int due; } pend_t;
    pend_t       pq[$];
    logic [31:0] mreg [8];
    logic        msf, mzf, mof;
    int          cyc = 0;
    int          n_cmp = 0, n_bad = 0;
    bit          run_chk = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Reference model, evaluated on every falling edge
    always @(negedge clk) if (run_chk) begin
        bit exp_done;
        exp_done = (pq.size() > 0) && (pq[0].due == cyc);
        check(done == exp_done, "R3", "done", 32'(done), 32'(exp_done));
        if (exp_done) begin
            pend_t p;
            logic [1:0]  md;
            logic [2:0]  s, d;
            logic [31:0] a, b, v;
            longint      full;
            bit known, wr, tf, nof;
            string tag;
            p = pq.pop_front();
            md = p.sel[7:6]; s = p.sel[5:3]; d = p.sel[2:0];
            a = mreg[d]; b = mreg[s];
            known = 1; wr = 1; tf = 1; nof = 0; v = 0; full = 0;
            case (p.op)
                8'h01: begin full = longint'($signed(a)) + longint'($signed(b)); tag = "R5"; end
                8'h29: begin full = longint'($signed(a)) - longint'($signed(b)); tag = "R5"; end
                8'h39: begin full = longint'($signed(a)) - longint'($signed(b)); tag = "R8"; wr = 0; end
                8'h21: begin v = a & b; tag = "R6"; end
                8'h09: begin v = a | b; tag = "R6"; end
                8'h31: begin v = a ^ b; tag = "R6"; end
                8'h89: begin v = b; tf = 0; tag = "R9"; end
                8'hF7: begin v = ~a; tag = "R10"; end
                default: begin known = 0; tag = "R12"; end
            endcase
            if (p.op == 8'h01 || p.op == 8'h29 || p.op == 8'h39) begin
                v = full[31:0];
                nof = (full != longint'($signed(v)));
            end
            if (!known || md != 2'b11) begin
                if (known) tag = "R11";
                check(fault == 1'b1, tag, "fault", 32'(fault), 32'd1);
                check(wr_en == 1'b0, tag, "wr_en", 32'(wr_en), 32'd0);
            end else begin
                check(fault == 1'b0, tag, "fault", 32'(fault), 32'd0);
                check(wr_en == wr, tag, "wr_en", 32'(wr_en), 32'(wr));
                check(result == v, tag, "result", result, v);
                if (wr) begin
                    check(wr_idx == d, "R4", "wr_idx", 32'(wr_idx), 32'(d));
                    mreg[d] = v;
                end
                if (tf) begin
                    msf = v[31]; mzf = (v == 0); mof = nof;
                end
            end
        end else begin
            check(!fault && !wr_en, "R3", "idle fault/wr_en", {30'd0, fault, wr_en}, 32'd0);
        end
        check({flag_s, flag_z, flag_o} == {msf, mzf, mof}, "R7", "flags SZO",
              {29'd0, flag_s, flag_z, flag_o}, {29'd0, msf, mzf, mof});
    end

    // Called at a falling edge; returns at the falling edge after acceptance
    task automatic send_byte(logic [7:0] b);
        byte_valid = 1'b1;
        byte_in    = b;
        while (!byte_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        byte_valid = 1'b0;
        byte_in    = 8'hxx;
    endtask

    task automatic issue(logic [7:0] op, logic [7:0] sel, int gap);
        pend_t p;
        send_byte(op);
        repeat (gap) @(negedge clk);
        send_byte(sel);
        p.op = op; p.sel = sel; p.due = cyc + 1;
        pq.push_back(p);
        check(byte_ready == 1'b0, "R2", "ready after selector", 32'(byte_ready), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        report();
    end

    initial begin
        logic [7:0] ops [9];
        ops = '{8'h01, 8'h29, 8'h21, 8'h09, 8'h31, 8'h39, 8'h89, 8'hF7, 8'h00};
        rst = 1'b1; byte_valid = 1'b0; byte_in = 8'h00;
        msf = 0; mzf = 0; mof = 0;
        for (int i = 0; i < 8; i++) mreg[i] = 32'h9E3779B9 * 32'(i + 1);
        repeat (3) @(negedge clk);
        // R1: reset state
        check(byte_ready == 1'b1, "R1", "ready", 32'(byte_ready), 32'd1);
        check(!done && !fault && !wr_en, "R1", "done/fault/wr_en", {29'd0, done, fault, wr_en}, 32'd0);
        check({flag_s, flag_z, flag_o} == 3'b000, "R1", "flags", {29'd0, flag_s, flag_z, flag_o}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        run_chk = 1;
        // R1: read every register back by a self-copy (R9)
        for (int i = 0; i < 8; i++) issue(8'h89, 8'(8'hC0 | (i << 3) | i), 0);
        // Directed corners
        issue(8'h01, 8'hC0, 0);   // R5 r0+r0: negative+negative overflows
        issue(8'h31, 8'hC9, 1);   // R6 xor r1,r1 -> zero, R7 ZF
        issue(8'h39, 8'hD2, 0);   // R8 compare equal
        issue(8'hF7, 8'hF9, 2);   // R10 not r1 with nonzero source field -> all ones
        issue(8'h29, 8'hCB, 0);   // R5 r3 - r1
        issue(8'h39, 8'hDA, 0);   // R8 r2 - r3
        issue(8'h39, 8'hD3, 0);   // R8 reversed
        issue(8'h89, 8'hE5, 0);   // R9 copy r4 -> r5, flags held
        issue(8'h21, 8'h18, 0);   // R11 mode 0
        issue(8'h01, 8'h58, 1);   // R11 mode 1
        issue(8'h09, 8'h9A, 0);   // R11 mode 2
        issue(8'h00, 8'hC0, 0);   // R12 unknown opcode
        issue(8'hFF, 8'hD8, 0);   // R12 unknown opcode
        issue(8'h09, 8'hE6, 0);   // R6 or
        issue(8'h21, 8'hF7, 0);   // R6 and
        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [7:0] sel;
            sel = 8'($urandom);
            if ($urandom_range(0, 9) < 8) sel[7:6] = 2'b11;
            issue(ops[$urandom_range(0, 8)], sel, $urandom_range(0, 2));
        end
        // Read back every register once more
        for (int i = 0; i < 8; i++) issue(8'h89, 8'(8'hC0 | (i << 3) | i), 0);
        repeat (4) @(negedge clk);
        check(pq.size() == 0, "R3", "pending retirements", 32'(pq.size()), 32'd0);
        report();
    end
endmodule